// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator

This block is the phase register of a digital frequency synthesiser. Every enabled clock it adds a frequency word to a wide running total, which wraps around at its full width. The output is the phase word that a later stage turns into an amplitude.

A plain adder of full width limits the clock to the delay of the whole ripple chain. Here the chain is cut in two, and a flip-flop sits between the halves. The lower slice adds its part of the increment and stores its carry-out. One cycle later the upper slice uses that stored carry as its carry-in. The upper part of the increment is delayed by one stage, so that it arrives together with its own carry. The lower part of the sum is also delayed by one stage, so that both halves of the output word come from the same step.

The block therefore takes a new increment every cycle, and each addition shows on the output a fixed two cycles after it is captured. The critical path covers only the wider of the two slices.

Top module: `pacc_top`

## Requirements
- R1: A synchronous reset, active high, clears the output and every internal stage to zero. The output is zero after the first clock edge that samples reset high, and reset takes priority over enable.
- R2: `inc_i` is sampled on every rising edge where `en` is high and `rst` is low. After the k-th such edge, `phase_o` equals the sum modulo 2^ACC_W of all increments captured on the enabled edges before the last two. Each increment therefore reaches the output two enabled edges after it is captured, and a new increment is accepted on every enabled edge.
- R3: A carry out of bit LO_W-1 of the lower slice is added into bit LO_W of the output in the same output step as the lower bits that caused it. The upper half is never one step behind the lower half.
- R4: The total wraps modulo 2^ACC_W. A carry out of the top bit is lost, and the output never saturates.
- R5: While `en` is low, every register holds its value and `phase_o` stays unchanged. Increments presented during those cycles are never added.
- R6: ACC_W and LO_W are parameters, and the upper slice has ACC_W-LO_W bits. The default is 32 bits split 16/16, and the behaviour in R2 holds for any legal split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the whole pipeline |
| inc_i | input | ACC_W | Frequency word added each enabled cycle |
| phase_o | output | ACC_W | Registered, aligned accumulator value |

## Verification
Two functions can act in the same cycle: a carry leaving the lower slice, and an overflow of the upper slice that makes the whole word wrap. The bench provokes both together. It sweeps every 8-bit increment on a 4/4 split and holds each one for several cycles, so the low nibble overflows while the high nibble sits at all ones. Every output is compared with a modular sum that the bench keeps itself. Enable gaps and a reset during the run are mixed into the stimulus, and a 32-bit default instance is judged the same way.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int unsigned PACC_W_DEF  = 32;
  localparam int unsigned PACC_LO_DEF = 16;
endpackage

// File: rtl/pacc_delay.sv
module pacc_delay #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)     q_o <= '0;
    else if (en) q_o <= d_i;
  end

  // R5: a frozen stage keeps its contents
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(q_o));
endmodule

// File: rtl/pacc_lo_slice.sv
module pacc_lo_slice #(
  parameter int LO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [LO_W-1:0] inc_i,
  output logic [LO_W-1:0] sum_o,
  output logic            carry_o
);
  logic [LO_W:0] add_w;
  assign add_w = {1'b0, sum_o} + {1'b0, inc_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else if (en) begin
      sum_o   <= add_w[LO_W-1:0];
      carry_o <= add_w[LO_W];
    end
  end

  // R3: the stored carry is set exactly when the lower slice wrapped
  assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (carry_o == (sum_o < $past(sum_o))));

  // R5: lower slice frozen while disabled
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(sum_o) && $stable(carry_o)));
endmodule

// File: rtl/pacc_hi_slice.sv
module pacc_hi_slice #(
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [HI_W-1:0] inc_i,
  input  logic            cin_i,
  output logic [HI_W-1:0] sum_o
);
  logic [HI_W-1:0] add_w;
  assign add_w = sum_o + inc_i + HI_W'(cin_i);

  always_ff @(posedge clk) begin
    if (rst)     sum_o <= '0;
    else if (en) sum_o <= add_w;
  end

  // R5: upper slice frozen while disabled
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(sum_o));
endmodule

// File: rtl/pacc_top.sv
module pacc_top #(
  parameter int ACC_W = pacc_pkg::PACC_W_DEF,
  parameter int LO_W  = pacc_pkg::PACC_LO_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] phase_o
);
  localparam int HI_W = ACC_W - LO_W;

  logic [ACC_W-1:0] inc_q;
  logic [LO_W-1:0]  lo_sum;
  logic [LO_W-1:0]  lo_aligned;
  logic             lo_carry;
  logic [HI_W-1:0]  hi_inc_skew;
  logic [HI_W-1:0]  hi_sum;

  // frequency word register
  always_ff @(posedge clk) begin
    if (rst)     inc_q <= '0;
    else if (en) inc_q <= inc_i;
  end

  pacc_lo_slice #(.LO_W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .en(en),
    .inc_i(inc_q[LO_W-1:0]),
    .sum_o(lo_sum), .carry_o(lo_carry)
  );

  // upper increment waits one stage for its carry
  pacc_delay #(.DW(HI_W)) u_skew (
    .clk(clk), .rst(rst), .en(en),
    .d_i(inc_q[ACC_W-1:LO_W]), .q_o(hi_inc_skew)
  );

  pacc_hi_slice #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .en(en),
    .inc_i(hi_inc_skew), .cin_i(lo_carry),
    .sum_o(hi_sum)
  );

  // lower result waits one stage to meet its upper half
  pacc_delay #(.DW(LO_W)) u_align (
    .clk(clk), .rst(rst), .en(en),
    .d_i(lo_sum), .q_o(lo_aligned)
  );

  assign phase_o = {hi_sum, lo_aligned};

  // R1: reset clears the visible phase on the next edge
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (phase_o == '0));

  // R5: output frozen while disabled
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(phase_o));

  // R3: aligned lower half equals what the lower slice held one step earlier
  assert_align_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (lo_aligned == $past(lo_sum)));
endmodule

// File: tb/pacc_top_test.sv
`timescale 1ns/1ps
module pacc_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [7:0]  inc8 = '0;
  logic [31:0] inc32 = '0;
  logic [7:0]  ph8;
  logic [31:0] ph32;

  int tests = 0;
  int fails = 0;

  // bench model: running sum and the last two captured words
  logic [7:0]  s8 = '0, a8 = '0, b8 = '0;
  logic [31:0] s32 = '0, a32 = '0, b32 = '0;

  always #2.5 clk = ~clk;

  pacc_top #(.ACC_W(8), .LO_W(4)) uut (
    .clk(clk), .rst(rst), .en(en), .inc_i(inc8), .phase_o(ph8)
  );

  pacc_top uut_wide (
    .clk(clk), .rst(rst), .en(en), .inc_i(inc32), .phase_o(ph32)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic [7:0] v,
                      input string tag);
    logic [7:0]  p8;
    logic [31:0] p32, w, e8x, e32;
    p8  = ph8;
    p32 = ph32;
    w   = {4{v}} ^ 32'h00A5_C3F1;
    rst = r; en = e; inc8 = v; inc32 = w;
    @(posedge clk);
    if (r) begin
      s8 = '0; a8 = '0; b8 = '0; s32 = '0; a32 = '0; b32 = '0;
    end else if (e) begin
      s8 = s8 + v;  b8 = a8;  a8 = v;
      s32 = s32 + w; b32 = a32; a32 = w;
    end
    @(negedge clk);
    e8x = {24'h0, s8 - a8 - b8};
    e32 = s32 - a32 - b32;
    chk(ph8 == e8x[7:0], tag, {24'h0, ph8}, e8x);
    chk(ph32 == e32, {tag, "/R6 wide"}, ph32, e32);
    if (!r && !e) begin
      chk(ph8 == p8, "R5 hold", {24'h0, ph8}, {24'h0, p8});
      chk(ph32 == p32, "R5 hold wide", ph32, p32);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, enable high during reset must not matter
    step(1'b1, 1'b0, 8'h00, "R1 reset");
    step(1'b1, 1'b1, 8'h5A, "R1 reset priority");
    chk(ph8 == 8'h00, "R1 zero", {24'h0, ph8}, 32'h0);

    // R2: latency of two, one word per cycle
    step(1'b0, 1'b1, 8'h01, "R2");
    step(1'b0, 1'b1, 8'h02, "R2");
    chk(ph8 == 8'h00, "R2 latency", {24'h0, ph8}, 32'h0);
    step(1'b0, 1'b1, 8'h04, "R2");
    chk(ph8 == 8'h01, "R2 first arrival", {24'h0, ph8}, 32'h1);

    // R3: low-nibble carries every cycle
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 8'h0F, "R3 carry");
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 8'h19, "R3 carry");

    // R4: wrap with all-ones and near-full words
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 8'hFF, "R4 wrap");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 8'hF1, "R4 wrap");

    // R2/R3/R4: every increment, held three cycles each
    for (int v = 0; v < 256; v++)
      for (int k = 0; k < 3; k++) step(1'b0, 1'b1, v[7:0], "R2 sweep");

    // R5: gaps with changing words that must be ignored
    for (int i = 0; i < 300; i++)
      step(1'b0, (i % 3) != 0, 8'(i * 37 + 11), "R5 gaps");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 8'(8'hC3 + i), "R5 frozen");

    // R1: reset in mid-run, then restart
    step(1'b1, 1'b1, 8'h77, "R1 mid reset");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 8'(i + 8'h88), "R2 restart");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule